// File: doc/BRIEF.md
# Quad-granular pixel wavefront packer

This block takes the per-clock output of a rasterizer and gathers it into fixed-size pixel wavefronts. Each input beat carries up to four 2x2 quads from one primitive, each with its own coverage mask and coordinates. The block places quads one after another into quad slots, so a single wavefront can hold quads from several primitives. A wavefront is closed when it is full, when one more primitive would exceed the primitive cap, or when a beat carries the end-of-draw flush bit.

A closed wavefront waits in one output register. It goes to the first compute unit that reports free space, searching in round-robin order from a rotating pointer. A beat is accepted only while the output register is empty or is being handed off in the same cycle. So no wavefront is ever dropped, and the rasterizer is stalled while every compute unit is full.

Top module: `wfpack_top`

## Requirements
- R1: Valid input quads (bit i of `in_qmask` set) enter the wavefront in ascending input index order, in the next free slots after those already filled. Input quads whose mask bit is clear are skipped and take no slot.
- R2: Slot k uses lanes 4k..4k+3. Lane 4k+i is live exactly when slot k is used and bit i of that quad's 4-bit coverage is set, with bits 0..3 meaning top-left, top-right, bottom-left, bottom-right. A used slot with zero coverage (helper quad) still occupies its slot. Unused slots report all-zero slot fields and dead lanes.
- R3: A wavefront is emitted as soon as all WAVE_QUADS slots are filled. Quads of the same beat that did not fit start the next wavefront from slot 0 in that cycle.
- R4: Within a wavefront, a beat with quads whose primitive ID differs from the previous placed beat starts a new primitive run. If that would make more than MAX_PRIMS runs, the open wavefront is emitted first and the beat starts a new one.
- R5: A beat with `in_flush` set emits the open wavefront, if it holds any quad, before its own quads are placed. An empty wavefront is never emitted. A beat with no valid quads and no flush changes nothing.
- R6: After reset the pointer is 0. A wavefront is dispatched to the first compute unit with `cu_space` set, searching upward from the pointer with wrap-around. The pointer then moves to the unit after the one that received it.
- R7: While `out_valid` is high and no `cu_space` bit is set, the wavefront stays in place with unchanged contents.
- R8: `in_ready` is high exactly when `out_valid` is low or a dispatch happens in this cycle.
- R9: After reset `out_valid` is 0, `in_ready` is 1 and the packer holds no quads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Beat accepted this cycle when high with in_valid |
| in_flush | input | 1 | Close the open wavefront before this beat's quads |
| in_prim | input | PRIM_W | Primitive ID of all quads in the beat |
| in_qmask | input | BEAT_QUADS | Per-quad valid bits |
| in_qx | input | BEAT_QUADS*COORD_W | Quad x coordinates, quad i at bits i*COORD_W |
| in_qy | input | BEAT_QUADS*COORD_W | Quad y coordinates |
| in_cov | input | BEAT_QUADS*4 | Quad coverage, quad i at bits 4i..4i+3 |
| cu_space | input | NUM_CU | Compute unit can accept a wavefront |
| out_valid | output | 1 | A wavefront is waiting for dispatch |
| out_cu | output | CU_W | Target compute unit; a dispatch happens when out_valid and any cu_space bit are set |
| out_slot_used | output | WAVE_QUADS | Per-slot occupied bits |
| out_lane_live | output | WAVE_QUADS*4 | Per-lane live bits |
| out_slot_x | output | WAVE_QUADS*COORD_W | Per-slot quad x |
| out_slot_y | output | WAVE_QUADS*COORD_W | Per-slot quad y |
| out_slot_prim | output | WAVE_QUADS*PRIM_W | Per-slot primitive ID |

## Verification
The bench keeps the 16-slot wavefront and 4-quad beat, but sets MAX_PRIMS to 3 and NUM_CU to 3. A primitive-cap closure then follows after a few short beats. The round-robin pointer wraps every three dispatches, so skip, wrap and stall cases all occur in a short run. With the full slot count, exact fills, partial fills and a two-quad overflow into the next wavefront all appear. Masked-out quads, helper quads with zero coverage and empty flush beats are mixed in.

// File: rtl/wfpack_pkg.sv
package wfpack_pkg;

    localparam int QUAD_LANES = 4;

    typedef enum logic [1:0] {
        CLOSE_NONE    = 2'd0,
        CLOSE_FULL    = 2'd1,
        CLOSE_PRIMCAP = 2'd2,
        CLOSE_FLUSH   = 2'd3
    } close_e;

    // next index in a ring of n entries
    function automatic int ring_next(input int idx, input int n);
        return (idx == n - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/wfpack_compact.sv
module wfpack_compact #(
    parameter int BEAT_QUADS = 4,
    parameter int COORD_W    = 8
) (
    input  logic [BEAT_QUADS-1:0]                qmask,
    input  logic [BEAT_QUADS-1:0][COORD_W-1:0]   qx,
    input  logic [BEAT_QUADS-1:0][COORD_W-1:0]   qy,
    input  logic [BEAT_QUADS-1:0][3:0]           qcov,
    output logic [BEAT_QUADS-1:0][COORD_W-1:0]   cx,
    output logic [BEAT_QUADS-1:0][COORD_W-1:0]   cy,
    output logic [BEAT_QUADS-1:0][3:0]           ccov,
    output logic [$clog2(BEAT_QUADS+1)-1:0]      count
);
    localparam int NW = $clog2(BEAT_QUADS + 1);

    // squeeze valid quads to the low positions, keeping arrival order
    always_comb begin
        int slot;
        slot = 0;
        cx   = '0;
        cy   = '0;
        ccov = '0;
        for (int i = 0; i < BEAT_QUADS; i++) begin
            if (qmask[i]) begin
                cx[slot]   = qx[i];
                cy[slot]   = qy[i];
                ccov[slot] = qcov[i];
                slot       = slot + 1;
            end
        end
        count = NW'(slot);
    end

endmodule

// File: rtl/wfpack_accum.sv
module wfpack_accum
    import wfpack_pkg::*;
#(
    parameter int WAVE_QUADS = 16,
    parameter int BEAT_QUADS = 4,
    parameter int MAX_PRIMS  = 16,
    parameter int COORD_W    = 8,
    parameter int PRIM_W     = 8
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 take,
    input  logic                                 flush,
    input  logic [PRIM_W-1:0]                    prim,
    input  logic [$clog2(BEAT_QUADS+1)-1:0]      n,
    input  logic [BEAT_QUADS-1:0][COORD_W-1:0]   cx,
    input  logic [BEAT_QUADS-1:0][COORD_W-1:0]   cy,
    input  logic [BEAT_QUADS-1:0][3:0]           ccov,
    output logic                                 emit,
    output logic [WAVE_QUADS-1:0]                e_used,
    output logic [WAVE_QUADS-1:0][COORD_W-1:0]   e_x,
    output logic [WAVE_QUADS-1:0][COORD_W-1:0]   e_y,
    output logic [WAVE_QUADS-1:0][PRIM_W-1:0]    e_prim,
    output logic [WAVE_QUADS-1:0][3:0]           e_cov
);
    localparam int FW  = $clog2(WAVE_QUADS + 1);
    localparam int RCW = $clog2(MAX_PRIMS + 1);

    // open wavefront
    logic [WAVE_QUADS-1:0]               a_used;
    logic [WAVE_QUADS-1:0][COORD_W-1:0]  a_x, a_y;
    logic [WAVE_QUADS-1:0][PRIM_W-1:0]   a_prim;
    logic [WAVE_QUADS-1:0][3:0]          a_cov;
    logic [FW-1:0]                       fill;
    logic [RCW-1:0]                      runs;
    logic [PRIM_W-1:0]                   last_prim;

    // merged (current wave after placement) and overflow (next wave)
    logic [WAVE_QUADS-1:0]               m_used, o_used;
    logic [WAVE_QUADS-1:0][COORD_W-1:0]  m_x, m_y, o_x, o_y;
    logic [WAVE_QUADS-1:0][PRIM_W-1:0]   m_prim, o_prim;
    logic [WAVE_QUADS-1:0][3:0]          m_cov, o_cov;

    logic   has_q, new_run, new_run_eff, pre_close, post_close;
    int     base, total;
    close_e reason;

    always_comb begin
        has_q       = (n != '0);
        new_run     = has_q && ((fill == '0) || (prim != last_prim));
        pre_close   = take && (fill != '0) &&
                      (flush || (new_run && (int'(runs) == MAX_PRIMS)));
        base        = pre_close ? 0 : int'(fill);
        total       = base + int'(n);
        post_close  = take && (total >= WAVE_QUADS);
        new_run_eff = has_q && ((base == 0) || (prim != last_prim));

        if (pre_close) begin
            m_used = '0; m_x = '0; m_y = '0; m_prim = '0; m_cov = '0;
        end else begin
            m_used = a_used; m_x = a_x; m_y = a_y; m_prim = a_prim; m_cov = a_cov;
        end
        o_used = '0; o_x = '0; o_y = '0; o_prim = '0; o_cov = '0;

        for (int j = 0; j < BEAT_QUADS; j++) begin
            if (j < int'(n)) begin
                if (base + j < WAVE_QUADS) begin
                    m_used[base + j] = 1'b1;
                    m_x[base + j]    = cx[j];
                    m_y[base + j]    = cy[j];
                    m_prim[base + j] = prim;
                    m_cov[base + j]  = ccov[j];
                end else begin
                    o_used[base + j - WAVE_QUADS] = 1'b1;
                    o_x[base + j - WAVE_QUADS]    = cx[j];
                    o_y[base + j - WAVE_QUADS]    = cy[j];
                    o_prim[base + j - WAVE_QUADS] = prim;
                    o_cov[base + j - WAVE_QUADS]  = ccov[j];
                end
            end
        end

        emit = pre_close || post_close;
        if (pre_close)       reason = flush ? CLOSE_FLUSH : CLOSE_PRIMCAP;
        else if (post_close) reason = CLOSE_FULL;
        else                 reason = CLOSE_NONE;

        if (pre_close) begin
            e_used = a_used; e_x = a_x; e_y = a_y; e_prim = a_prim; e_cov = a_cov;
        end else begin
            e_used = m_used; e_x = m_x; e_y = m_y; e_prim = m_prim; e_cov = m_cov;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_used    <= '0;
            a_x       <= '0;
            a_y       <= '0;
            a_prim    <= '0;
            a_cov     <= '0;
            fill      <= '0;
            runs      <= '0;
            last_prim <= '0;
        end else if (take) begin
            if (has_q) last_prim <= prim;
            if (post_close) begin
                a_used <= o_used; a_x <= o_x; a_y <= o_y; a_prim <= o_prim; a_cov <= o_cov;
                fill   <= FW'(total - WAVE_QUADS);
                runs   <= (total > WAVE_QUADS) ? RCW'(1) : '0;
            end else begin
                a_used <= m_used; a_x <= m_x; a_y <= m_y; a_prim <= m_prim; a_cov <= m_cov;
                fill   <= FW'(total);
                runs   <= (pre_close ? '0 : runs) + RCW'(new_run_eff);
            end
        end
    end

    // R4: open wave never holds more primitive runs than the cap
    p_run_cap_r4: assert property (@(posedge clk) disable iff (rst)
        int'(runs) <= MAX_PRIMS);

    // R3: a full wave is never left sitting in the packer
    p_never_full_r3: assert property (@(posedge clk) disable iff (rst)
        int'(fill) < WAVE_QUADS);

    // R5: a flush beat leaves only its own quads behind
    p_flush_leaves_beat_r5: assert property (@(posedge clk) disable iff (rst)
        take && flush |=> fill == FW'($past(n)));

    // R5: an emitted wave is never empty and has a closing cause
    p_emit_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        emit |-> (|e_used) && (reason != CLOSE_NONE));

endmodule

// File: rtl/wfpack_dispatch.sv
module wfpack_dispatch
    import wfpack_pkg::*;
#(
    parameter int WAVE_QUADS = 16,
    parameter int NUM_CU     = 4,
    parameter int COORD_W    = 8,
    parameter int PRIM_W     = 8,
    parameter int CU_W       = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 load,
    input  logic [WAVE_QUADS-1:0]                l_used,
    input  logic [WAVE_QUADS-1:0][COORD_W-1:0]   l_x,
    input  logic [WAVE_QUADS-1:0][COORD_W-1:0]   l_y,
    input  logic [WAVE_QUADS-1:0][PRIM_W-1:0]    l_prim,
    input  logic [WAVE_QUADS-1:0][3:0]           l_cov,
    input  logic [NUM_CU-1:0]                    cu_space,
    output logic                                 out_valid,
    output logic [CU_W-1:0]                      pick,
    output logic                                 fire,
    output logic [WAVE_QUADS-1:0]                o_used,
    output logic [WAVE_QUADS-1:0][COORD_W-1:0]   o_x,
    output logic [WAVE_QUADS-1:0][COORD_W-1:0]   o_y,
    output logic [WAVE_QUADS-1:0][PRIM_W-1:0]    o_prim,
    output logic [WAVE_QUADS-1:0][3:0]           o_cov
);
    logic [CU_W-1:0] rr;
    logic            any_space;

    // first unit with room, searching upward from the pointer
    always_comb begin
        pick      = rr;
        any_space = 1'b0;
        for (int k = NUM_CU - 1; k >= 0; k--) begin
            if (cu_space[(int'(rr) + k) % NUM_CU]) begin
                pick      = CU_W'((int'(rr) + k) % NUM_CU);
                any_space = 1'b1;
            end
        end
        fire = out_valid && any_space;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr        <= '0;
            out_valid <= 1'b0;
            o_used    <= '0;
            o_x       <= '0;
            o_y       <= '0;
            o_prim    <= '0;
            o_cov     <= '0;
        end else begin
            if (fire) rr <= CU_W'(ring_next(int'(pick), NUM_CU));
            if (load) begin
                out_valid <= 1'b1;
                o_used    <= l_used;
                o_x       <= l_x;
                o_y       <= l_y;
                o_prim    <= l_prim;
                o_cov     <= l_cov;
            end else if (fire) begin
                out_valid <= 1'b0;
            end
        end
    end

    // R7: a stalled wave stays put and unchanged
    p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !fire |=> out_valid && $stable(o_used) && $stable(o_x) && $stable(o_prim));

    // R8: a new wave only arrives when the register is free or draining
    p_load_when_free_r8: assert property (@(posedge clk) disable iff (rst)
        load |-> !out_valid || fire);

    // R6: pointer only moves on a dispatch
    p_ptr_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(rr));

endmodule

// File: rtl/wfpack_top.sv
module wfpack_top
    import wfpack_pkg::*;
#(
    parameter int WAVE_QUADS = 16,
    parameter int BEAT_QUADS = 4,
    parameter int MAX_PRIMS  = 16,
    parameter int NUM_CU     = 4,
    parameter int COORD_W    = 8,
    parameter int PRIM_W     = 8,
    parameter int CU_W       = (NUM_CU > 1) ? $clog2(NUM_CU) : 1
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               in_valid,
    output logic                               in_ready,
    input  logic                               in_flush,
    input  logic [PRIM_W-1:0]                  in_prim,
    input  logic [BEAT_QUADS-1:0]              in_qmask,
    input  logic [BEAT_QUADS*COORD_W-1:0]      in_qx,
    input  logic [BEAT_QUADS*COORD_W-1:0]      in_qy,
    input  logic [BEAT_QUADS*4-1:0]            in_cov,
    input  logic [NUM_CU-1:0]                  cu_space,
    output logic                               out_valid,
    output logic [CU_W-1:0]                    out_cu,
    output logic [WAVE_QUADS-1:0]              out_slot_used,
    output logic [WAVE_QUADS*QUAD_LANES-1:0]   out_lane_live,
    output logic [WAVE_QUADS*COORD_W-1:0]      out_slot_x,
    output logic [WAVE_QUADS*COORD_W-1:0]      out_slot_y,
    output logic [WAVE_QUADS*PRIM_W-1:0]       out_slot_prim
);
    localparam int NW = $clog2(BEAT_QUADS + 1);

    logic [BEAT_QUADS-1:0][COORD_W-1:0] qx, qy, cx, cy;
    logic [BEAT_QUADS-1:0][3:0]         qcov, ccov;
    logic [NW-1:0]                      cnt;
    logic                               take, emit, fire;

    logic [WAVE_QUADS-1:0]               e_used, o_used;
    logic [WAVE_QUADS-1:0][COORD_W-1:0]  e_x, e_y, o_x, o_y;
    logic [WAVE_QUADS-1:0][PRIM_W-1:0]   e_prim, o_prim;
    logic [WAVE_QUADS-1:0][3:0]          e_cov, o_cov;

    assign qx       = in_qx;
    assign qy       = in_qy;
    assign qcov     = in_cov;
    assign in_ready = !out_valid || fire;
    assign take     = in_valid && in_ready;

    wfpack_compact #(
        .BEAT_QUADS (BEAT_QUADS),
        .COORD_W    (COORD_W)
    ) u_compact (
        .qmask (in_qmask),
        .qx    (qx),
        .qy    (qy),
        .qcov  (qcov),
        .cx    (cx),
        .cy    (cy),
        .ccov  (ccov),
        .count (cnt)
    );

    wfpack_accum #(
        .WAVE_QUADS (WAVE_QUADS),
        .BEAT_QUADS (BEAT_QUADS),
        .MAX_PRIMS  (MAX_PRIMS),
        .COORD_W    (COORD_W),
        .PRIM_W     (PRIM_W)
    ) u_accum (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .flush  (in_flush),
        .prim   (in_prim),
        .n      (cnt),
        .cx     (cx),
        .cy     (cy),
        .ccov   (ccov),
        .emit   (emit),
        .e_used (e_used),
        .e_x    (e_x),
        .e_y    (e_y),
        .e_prim (e_prim),
        .e_cov  (e_cov)
    );

    wfpack_dispatch #(
        .WAVE_QUADS (WAVE_QUADS),
        .NUM_CU     (NUM_CU),
        .COORD_W    (COORD_W),
        .PRIM_W     (PRIM_W),
        .CU_W       (CU_W)
    ) u_dispatch (
        .clk       (clk),
        .rst       (rst),
        .load      (emit),
        .l_used    (e_used),
        .l_x       (e_x),
        .l_y       (e_y),
        .l_prim    (e_prim),
        .l_cov     (e_cov),
        .cu_space  (cu_space),
        .out_valid (out_valid),
        .pick      (out_cu),
        .fire      (fire),
        .o_used    (o_used),
        .o_x       (o_x),
        .o_y       (o_y),
        .o_prim    (o_prim),
        .o_cov     (o_cov)
    );

    assign out_slot_used = o_used;
    assign out_slot_x    = o_x;
    assign out_slot_y    = o_y;
    assign out_slot_prim = o_prim;

    for (genvar s = 0; s < WAVE_QUADS; s++) begin : g_slot
        for (genvar l = 0; l < QUAD_LANES; l++) begin : g_lane
            assign out_lane_live[s*QUAD_LANES + l] = o_used[s] & o_cov[s][l];
        end
    end

    // R8: input is only held off while a wave waits undelivered
    p_ready_r8: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid && !(|cu_space));

    // R2: live lanes only appear in occupied slots
    p_lane_in_slot_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lane_live[3:0] == '0) || out_slot_used[0]);

endmodule

// File: tb/wfpack_top_tb.sv
module wfpack_top_tb;
    localparam int WQ  = 16;
    localparam int BQ  = 4;
    localparam int MAXP = 3;
    localparam int NCU = 3;
    localparam int CW  = 8;
    localparam int PW  = 8;
    localparam int CUW = 2;
    localparam int NV  = 22;

    // {flush, prim[3:0], qmask[3:0], cov[15:0]}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 4'd1,  4'hF, 16'hFFFF},
        {1'b0, 4'd1,  4'hF, 16'h1248},
        {1'b0, 4'd2,  4'h5, 16'h0A0C},   // R1: masked-out quads skipped
        {1'b0, 4'd2,  4'hA, 16'h3000},   // R2: helper quad with no coverage
        {1'b0, 4'd3,  4'hF, 16'h9F61},   // R3: exact fill
        {1'b0, 4'd4,  4'h3, 16'h00E7},
        {1'b0, 4'd5,  4'h7, 16'h0421},
        {1'b0, 4'd6,  4'h1, 16'h000B},
        {1'b0, 4'd7,  4'hF, 16'hFFFF},   // R4: fourth run closes the wave
        {1'b0, 4'd7,  4'hF, 16'h5A5A},
        {1'b0, 4'd8,  4'hF, 16'hC3C3},
        {1'b0, 4'd8,  4'hF, 16'h0F0F},
        {1'b0, 4'd9,  4'h7, 16'h0777},
        {1'b0, 4'd9,  4'hF, 16'h8888},
        {1'b0, 4'd9,  4'hF, 16'h1111},
        {1'b0, 4'd10, 4'hF, 16'h2222},
        {1'b0, 4'd10, 4'h7, 16'h0ABC},   // R3: two quads overflow
        {1'b1, 4'd10, 4'h0, 16'h0000},   // R5: flush partial
        {1'b1, 4'd10, 4'h0, 16'h0000},   // R5: flush on empty
        {1'b1, 4'd11, 4'h6, 16'h0D70},
        {1'b0, 4'd12, 4'h0, 16'hFFFF},   // R5: empty beat ignored
        {1'b1, 4'd12, 4'h0, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_flush = 1'b0;
    logic in_ready;
    logic [PW-1:0] in_prim = '0;
    logic [BQ-1:0] in_qmask = '0;
    logic [BQ*CW-1:0] in_qx = '0, in_qy = '0;
    logic [BQ*4-1:0] in_cov = '0;
    logic [NCU-1:0] cu_space = '1;
    logic out_valid;
    logic [CUW-1:0] out_cu;
    logic [WQ-1:0] out_slot_used;
    logic [WQ*4-1:0] out_lane_live;
    logic [WQ*CW-1:0] out_slot_x, out_slot_y;
    logic [WQ*PW-1:0] out_slot_prim;

    always #2 clk = ~clk;

    wfpack_top #(
        .WAVE_QUADS (WQ), .BEAT_QUADS (BQ), .MAX_PRIMS (MAXP),
        .NUM_CU (NCU), .COORD_W (CW), .PRIM_W (PW), .CU_W (CUW)
    ) u_dut (
        .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
        .in_flush (in_flush), .in_prim (in_prim), .in_qmask (in_qmask),
        .in_qx (in_qx), .in_qy (in_qy), .in_cov (in_cov), .cu_space (cu_space),
        .out_valid (out_valid), .out_cu (out_cu), .out_slot_used (out_slot_used),
        .out_lane_live (out_lane_live), .out_slot_x (out_slot_x),
        .out_slot_y (out_slot_y), .out_slot_prim (out_slot_prim)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [WQ-1:0]    m_used = '0;
    logic [WQ*CW-1:0] m_x = '0, m_y = '0;
    logic [WQ*PW-1:0] m_prim = '0;
    logic [WQ*4-1:0]  m_cov = '0;
    int m_fill = 0, m_runs = 0, m_rr = 0;
    logic [PW-1:0] m_last = '0;

    logic [WQ-1:0]    x_used [64];
    logic [WQ*4-1:0]  x_live [64];
    logic [WQ*CW-1:0] x_x [64], x_y [64];
    logic [WQ*PW-1:0] x_prim [64];
    string            x_tag [64];
    int n_exp = 0, n_got = 0;

    task automatic push_wave(input string tag);
        x_used[n_exp] = m_used; x_live[n_exp] = m_cov;
        x_x[n_exp] = m_x; x_y[n_exp] = m_y; x_prim[n_exp] = m_prim;
        x_tag[n_exp] = tag;
        n_exp++;
        m_used = '0; m_x = '0; m_y = '0; m_prim = '0; m_cov = '0;
        m_fill = 0; m_runs = 0;
    endtask

    task automatic model_beat(input bit fl, input logic [PW-1:0] p, input logic [3:0] mask,
                              input logic [15:0] cov, input logic [5:0] bn);
        int n;
        n = $countones(mask);
        if (m_fill != 0 && (fl || (n > 0 && p != m_last && m_runs == MAXP)))
            push_wave(fl ? "R5 flush" : "R4 prim cap");
        if (n > 0) begin
            if (m_fill == 0 || p != m_last) m_runs++;
            m_last = p;
        end
        for (int i = 0; i < BQ; i++) begin
            if (mask[i]) begin
                if (m_fill == 0 && m_runs == 0) m_runs = 1;
                m_used[m_fill] = 1'b1;
                m_x[m_fill*CW +: CW] = {bn, 2'(i)};
                m_y[m_fill*CW +: CW] = p;
                m_prim[m_fill*PW +: PW] = p;
                m_cov[m_fill*4 +: 4] = cov[i*4 +: 4];
                m_fill++;
                if (m_fill == WQ) push_wave("R3 full");
            end
        end
    endtask

    function automatic int pick_cu(input logic [NCU-1:0] sp, input int ptr);
        for (int k = 0; k < NCU; k++)
            if (sp[(ptr + k) % NCU]) return (ptr + k) % NCU;
        return -1;
    endfunction

    // drive one beat, wait for acceptance, update the model
    task automatic send(input bit fl, input logic [PW-1:0] p, input logic [3:0] mask,
                        input logic [15:0] cov, input logic [5:0] bn);
        bit rd;
        in_valid = 1'b1; in_flush = fl; in_prim = p; in_qmask = mask; in_cov = cov;
        for (int i = 0; i < BQ; i++) begin
            in_qx[i*CW +: CW] = {bn, 2'(i)};
            in_qy[i*CW +: CW] = p;
        end
        do begin
            @(negedge clk);
            rd = in_ready;
            @(posedge clk);
            #1;
        end while (!rd);
        model_beat(fl, p, mask, cov, bn);
        in_valid = 1'b0; in_flush = 1'b0; in_qmask = '0;
    endtask

    // dispatch monitor
    always @(negedge clk) begin
        if (!rst && out_valid && (|cu_space)) begin
            int ecu;
            ecu = pick_cu(cu_space, m_rr);
            if (n_got < n_exp) begin
                chk(out_slot_used == x_used[n_got], {x_tag[n_got], " R1 slot use"}, 128'(out_slot_used), 128'(x_used[n_got]));
                chk(out_lane_live == x_live[n_got], "R2 lane live", 128'(out_lane_live), 128'(x_live[n_got]));
                chk(out_slot_x == x_x[n_got] && out_slot_y == x_y[n_got], {x_tag[n_got], " R1 coords"}, out_slot_x, x_x[n_got]);
                chk(out_slot_prim == x_prim[n_got], {x_tag[n_got], " R4 prims"}, out_slot_prim, x_prim[n_got]);
            end else begin
                chk(1'b0, "R5 unexpected wave", 128'(n_got), 128'(n_exp));
            end
            chk(int'(out_cu) == ecu, "R6 target unit", 128'(out_cu), 128'(ecu));
            m_rr = (ecu + 1) % NCU;
            n_got++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid after reset", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R9 in_ready after reset", 128'(in_ready), 128'(1));
        @(posedge clk); #1;

        for (int v = 0; v < NV; v++) begin
            send(VEC[v][24], PW'(VEC[v][23:20]), VEC[v][19:16], VEC[v][15:0], 6'(v));
        end
        repeat (4) @(posedge clk);
        #1;
        chk(n_got == n_exp && n_exp == 6, "R5 table wave count", 128'(n_got), 128'(6));

        // R7/R8: stall with no unit free
        cu_space = '0;
        for (int b = 0; b < 4; b++) send(1'b0, 8'd20, 4'hF, 16'hFFFF, 6'(30 + b));
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R7 wave held", 128'(out_valid), 128'(1));
            chk(in_ready == 1'b0, "R8 input stalled", 128'(in_ready), 128'(0));
            chk(out_slot_used == 16'hFFFF, "R7 contents kept", 128'(out_slot_used), 128'(16'hFFFF));
        end
        @(posedge clk); #1;
        cu_space = 3'b010;             // R6: pointer unit has no room, skip to unit 1
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready while dispatching", 128'(in_ready), 128'(1));
        @(posedge clk); #1;

        // R6: skip and wrap with units 0 and 2 free
        cu_space = 3'b101;
        for (int b = 0; b < 4; b++) send(1'b0, 8'd21, 4'hF, 16'h8421, 6'(40 + b));
        for (int b = 0; b < 4; b++) send(1'b0, 8'd22, 4'hF, 16'h1234, 6'(44 + b));
        repeat (4) @(posedge clk);
        #1;
        chk(n_got == n_exp && n_exp == 9, "R3 final wave count", 128'(n_got), 128'(9));
        @(negedge clk);
        chk(out_valid == 1'b0, "R6 all dispatched", 128'(out_valid), 128'(0));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule